// File: doc/BRIEF.md
# I2C Single-Byte Register Access Sequencer

This block carries out one register read or one register write on an I2C target device. It does this by driving the register port of an I2C master whose progress is reported through status codes. A request strobe captures the operation, the 7-bit device address, the 8-bit register index and the byte to write. The sequencer then issues reads and writes to the master's registers. After every bus action it polls the master's interrupt flag under a bounded poll budget and compares the reported status against the one exact code that action should produce.

Any failure skips the remaining steps. The block then enters a closing stop phase, which runs after both successful and failed transfers. The stop phase requests a STOP condition and then confirms three things, each with its own poll budget: the STOP bit has cleared, the master is idle, and both bus lines are high. When everything finishes, the block raises a one-cycle completion pulse and an error flag. The error flag summarises the whole transfer. For reads, the received byte appears on a registered output.

Top module: `i2c_regxfer_seq`

## Requirements
- R1: After reset, `done_o` and `err_o` are 0 and no register access is issued until a request is accepted.
- R2: Each transfer first writes 0 to the feature register (offset 3) and then reads the status register (offset 2). Unless the status is 0xF8, the transfer issues no START, goes directly to the stop phase and reports an error.
- R3: A write sends START (status 0x08), then loads the data register (offset 0) with the address shifted left with bit 0 = 0 (0x18), then the index (0x28), then the write byte (0x28), in that order.
- R4: A read performs START, the address with bit 0 = 0 and the index as in R3. It then issues a repeated START (0x10), loads the address with bit 0 = 1 (0x40) and receives one byte (0x58). That byte, read from offset 0, appears on `rbyte_o` when the transfer completes without error.
- R5: After each action the control register (offset 1) is read at most LIMIT times while waiting for the flag (bit 3). A flag seen on read LIMIT counts as success; a flag that has not appeared by read LIMIT is an error.
- R6: A status code that differs from the expected one at any step ends the transfer with an error, and the stop phase still runs exactly once.
- R7: Every control write keeps bits 7:6 as they were read back. An advance writes START (bit 5) and STOP (bit 4) as 0 and the flag as 1. A repeated START writes bit 5 and the flag as 1.
- R8: The stop phase writes STOP and the flag as 1 while keeping bits 7:6. Each of the following waits has its own LIMIT-read budget: STOP reading back 0, status 0xF8, and line state (offset 4) 0x3A. Any of these waits running out is an error.
- R9: `done_o` is high for exactly one cycle per accepted request. `err_o` is updated in that cycle and holds until the next request is accepted.
- R10: Requests that arrive while a transfer is in progress are ignored.
- R11: The block never reads and writes in the same cycle, and never writes START and STOP together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, accepted when idle |
| op_rd_i | input | 1 | 1 = register read, 0 = register write |
| dev_i | input | 7 | Target device address |
| index_i | input | 8 | Register index inside the target |
| wbyte_i | input | 8 | Byte to write |
| rbyte_o | output | 8 | Byte received by a read |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Transfer failed, valid from `done_o` |
| bus_rd_o | output | 1 | Master register read strobe |
| bus_wr_o | output | 1 | Master register write strobe |
| bus_addr_o | output | 3 | Master register offset |
| bus_wdata_o | output | 8 | Master register write data |
| bus_rdata_i | input | 8 | Master register read data, valid the second cycle after the strobe |

## Verification
The bench builds the sequencer with LIMIT = 4, so a flag arriving on read 1, 2, 3, 4 and 5 covers both sides of the poll budget in a few cycles. With that budget small, the bench can sweep every action of both operations in two ways: once with a corrupted status code and once with a flag that never arrives. It also exercises a busy master at entry, a stuck bus line and requests sent during a transfer. For each case, the expected byte stream, error outcome and stop count are worked out arithmetically.

// File: rtl/i2c_regxfer_pkg.sv
package i2c_regxfer_pkg;

  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;
  localparam int RA_W   = 3;

  localparam logic [RA_W-1:0] RA_DATA = 3'd0;
  localparam logic [RA_W-1:0] RA_CTL  = 3'd1;
  localparam logic [RA_W-1:0] RA_STAT = 3'd2;
  localparam logic [RA_W-1:0] RA_FEAT = 3'd3;
  localparam logic [RA_W-1:0] RA_LINE = 3'd4;

  localparam int B_START = 5;
  localparam int B_STOP  = 4;
  localparam int B_FLAG  = 3;

  localparam logic [BYTE_W-1:0] ST_IDLE   = 8'hF8;
  localparam logic [BYTE_W-1:0] LINE_HIGH = 8'h3A;

  typedef enum logic [2:0] {
    STEP_START   = 3'd0,
    STEP_ADDRW   = 3'd1,
    STEP_INDEX   = 3'd2,
    STEP_WDATA   = 3'd3,
    STEP_RESTART = 3'd4,
    STEP_ADDRR   = 3'd5,
    STEP_RECV    = 3'd6
  } step_e;

  typedef enum logic [1:0] {
    CK_START   = 2'd0,
    CK_ADV     = 2'd1,
    CK_RESTART = 2'd2
  } ctl_kind_e;

  typedef struct packed {
    logic              load;
    logic [BYTE_W-1:0] load_byte;
    ctl_kind_e         kind;
    logic [BYTE_W-1:0] expect_st;
    logic              recv;
    logic              last;
    step_e             next;
  } step_info_t;

  function automatic logic [BYTE_W-1:0] ctl_rewrite(ctl_kind_e k, logic [BYTE_W-1:0] cur);
    case (k)
      CK_START:   ctl_rewrite = cur | 8'h20;
      CK_RESTART: ctl_rewrite = (cur & 8'hC0) | 8'h28;
      default:    ctl_rewrite = (cur & 8'hCF) | 8'h08;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] ctl_stop(logic [BYTE_W-1:0] cur);
    ctl_stop = (cur & 8'hC0) | 8'h18;
  endfunction

endpackage

// File: rtl/i2c_regxfer_step.sv
module i2c_regxfer_step
  import i2c_regxfer_pkg::*;
(
  input  step_e              step,
  input  logic               op_rd,
  input  logic [DEV_W-1:0]   dev,
  input  logic [BYTE_W-1:0]  index,
  input  logic [BYTE_W-1:0]  wbyte,
  output step_info_t         info
);

  always_comb begin
    info           = '0;
    info.kind      = CK_ADV;
    info.next      = step_e'(step + 3'd1);
    case (step)
      STEP_START: begin
        info.kind      = CK_START;
        info.expect_st = 8'h08;
      end
      STEP_ADDRW: begin
        info.load      = 1'b1;
        info.load_byte = {dev, 1'b0};
        info.expect_st = 8'h18;
      end
      STEP_INDEX: begin
        info.load      = 1'b1;
        info.load_byte = index;
        info.expect_st = 8'h28;
        info.next      = op_rd ? STEP_RESTART : STEP_WDATA;
      end
      STEP_WDATA: begin
        info.load      = 1'b1;
        info.load_byte = wbyte;
        info.expect_st = 8'h28;
        info.last      = 1'b1;
      end
      STEP_RESTART: begin
        info.kind      = CK_RESTART;
        info.expect_st = 8'h10;
      end
      STEP_ADDRR: begin
        info.load      = 1'b1;
        info.load_byte = {dev, 1'b1};
        info.expect_st = 8'h40;
      end
      default: begin
        info.recv      = 1'b1;
        info.expect_st = 8'h58;
        info.last      = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/i2c_regxfer_timer.sv
module i2c_regxfer_timer #(
  parameter int LIMIT = 767,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic          last,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/i2c_regxfer_seq.sv
module i2c_regxfer_seq
  import i2c_regxfer_pkg::*;
#(
  parameter int LIMIT = 767,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              op_rd_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [BYTE_W-1:0] index_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  output logic [BYTE_W-1:0] rbyte_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [RA_W-1:0]   bus_addr_o,
  output logic [BYTE_W-1:0] bus_wdata_o,
  input  logic [BYTE_W-1:0] bus_rdata_i
);

  typedef enum logic [4:0] {
    S_IDLE, S_FEAT, S_PRE_R, S_RWAIT, S_PRE_E, S_LOAD, S_CTL_R, S_CTL_W,
    S_POLL_R, S_POLL_E, S_DAT_R, S_DAT_E, S_ST_R, S_ST_E,
    S_SP_R, S_SP_W, S_SW_R, S_SW_E, S_FIN
  } state_e;

  state_e            state, ret;
  step_e             step;
  step_info_t        info;
  logic              op_rd_q, err_q;
  logic [DEV_W-1:0]  dev_q;
  logic [BYTE_W-1:0] index_q, wbyte_q;
  logic [1:0]        wph;
  logic              t_clr, t_inc, t_last;
  logic [CW-1:0]     poll_cnt;
  logic              sw_ok;

  i2c_regxfer_step step_i (
    .step  (step),
    .op_rd (op_rd_q),
    .dev   (dev_q),
    .index (index_q),
    .wbyte (wbyte_q),
    .info  (info)
  );

  i2c_regxfer_timer #(.LIMIT(LIMIT)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (t_clr),
    .inc  (t_inc),
    .last (t_last),
    .cnt  (poll_cnt)
  );

  always_comb begin
    case (wph)
      2'd0:    sw_ok = !bus_rdata_i[B_STOP];
      2'd1:    sw_ok = (bus_rdata_i == ST_IDLE);
      default: sw_ok = (bus_rdata_i == LINE_HIGH);
    endcase
  end

  always_comb begin
    t_clr = (state == S_CTL_W) || (state == S_SP_W) || (state == S_SW_E && sw_ok);
    t_inc = ((state == S_POLL_E) && !bus_rdata_i[B_FLAG] && !t_last) ||
            ((state == S_SW_E) && !sw_ok && !t_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      ret         <= S_IDLE;
      step        <= STEP_START;
      op_rd_q     <= 1'b0;
      dev_q       <= '0;
      index_q     <= '0;
      wbyte_q     <= '0;
      err_q       <= 1'b0;
      wph         <= 2'd0;
      rbyte_o     <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      bus_rd_o    <= 1'b0;
      bus_wr_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else begin
      bus_rd_o <= 1'b0;
      bus_wr_o <= 1'b0;
      done_o   <= 1'b0;
      case (state)
        S_IDLE: if (req_i) begin
          op_rd_q <= op_rd_i;
          dev_q   <= dev_i;
          index_q <= index_i;
          wbyte_q <= wbyte_i;
          err_q   <= 1'b0;
          err_o   <= 1'b0;
          step    <= STEP_START;
          state   <= S_FEAT;
        end
        S_FEAT: begin
          bus_wr_o    <= 1'b1;
          bus_addr_o  <= RA_FEAT;
          bus_wdata_o <= '0;
          state       <= S_PRE_R;
        end
        S_PRE_R: begin
          bus_rd_o   <= 1'b1;
          bus_addr_o <= RA_STAT;
          ret        <= S_PRE_E;
          state      <= S_RWAIT;
        end
        S_RWAIT: state <= ret;
        S_PRE_E: begin
          if (bus_rdata_i == ST_IDLE) state <= S_LOAD;
          else begin
            err_q <= 1'b1;
            state <= S_SP_R;
          end
        end
        S_LOAD: begin
          if (info.load) begin
            bus_wr_o    <= 1'b1;
            bus_addr_o  <= RA_DATA;
            bus_wdata_o <= info.load_byte;
          end
          state <= S_CTL_R;
        end
        S_CTL_R: begin
          bus_rd_o   <= 1'b1;
          bus_addr_o <= RA_CTL;
          ret        <= S_CTL_W;
          state      <= S_RWAIT;
        end
        S_CTL_W: begin
          bus_wr_o    <= 1'b1;
          bus_addr_o  <= RA_CTL;
          bus_wdata_o <= ctl_rewrite(info.kind, bus_rdata_i);
          state       <= S_POLL_R;
        end
        S_POLL_R: begin
          bus_rd_o   <= 1'b1;
          bus_addr_o <= RA_CTL;
          ret        <= S_POLL_E;
          state      <= S_RWAIT;
        end
        S_POLL_E: begin
          if (bus_rdata_i[B_FLAG]) state <= info.recv ? S_DAT_R : S_ST_R;
          else if (t_last) begin
            err_q <= 1'b1;
            state <= S_SP_R;
          end else state <= S_POLL_R;
        end
        S_DAT_R: begin
          bus_rd_o   <= 1'b1;
          bus_addr_o <= RA_DATA;
          ret        <= S_DAT_E;
          state      <= S_RWAIT;
        end
        S_DAT_E: begin
          rbyte_o <= bus_rdata_i;
          state   <= S_ST_R;
        end
        S_ST_R: begin
          bus_rd_o   <= 1'b1;
          bus_addr_o <= RA_STAT;
          ret        <= S_ST_E;
          state      <= S_RWAIT;
        end
        S_ST_E: begin
          if (bus_rdata_i != info.expect_st) begin
            err_q <= 1'b1;
            state <= S_SP_R;
          end else if (info.last) state <= S_SP_R;
          else begin
            step  <= info.next;
            state <= S_LOAD;
          end
        end
        S_SP_R: begin
          bus_rd_o   <= 1'b1;
          bus_addr_o <= RA_CTL;
          ret        <= S_SP_W;
          state      <= S_RWAIT;
        end
        S_SP_W: begin
          bus_wr_o    <= 1'b1;
          bus_addr_o  <= RA_CTL;
          bus_wdata_o <= ctl_stop(bus_rdata_i);
          wph         <= 2'd0;
          state       <= S_SW_R;
        end
        S_SW_R: begin
          bus_rd_o   <= 1'b1;
          bus_addr_o <= (wph == 2'd0) ? RA_CTL : (wph == 2'd1) ? RA_STAT : RA_LINE;
          ret        <= S_SW_E;
          state      <= S_RWAIT;
        end
        S_SW_E: begin
          if (sw_ok) begin
            if (wph == 2'd2) state <= S_FIN;
            else begin
              wph   <= wph + 2'd1;
              state <= S_SW_R;
            end
          end else if (t_last) begin
            err_q <= 1'b1;
            state <= S_FIN;
          end else state <= S_SW_R;
        end
        S_FIN: begin
          done_o <= 1'b1;
          err_o  <= err_q;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_regxfer_seq_chk.sv
module i2c_regxfer_seq_chk
  import i2c_regxfer_pkg::*;
#(
  parameter int LIMIT = 767,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              done_o,
  input logic              err_o,
  input logic              bus_rd_o,
  input logic              bus_wr_o,
  input logic [RA_W-1:0]   bus_addr_o,
  input logic [BYTE_W-1:0] bus_wdata_o,
  input logic [BYTE_W-1:0] bus_rdata_i,
  input logic [CW-1:0]     poll_cnt
);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o);

  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd_o && bus_wr_o));

  assert_no_start_stop_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_o && bus_addr_o == RA_CTL) |-> !(bus_wdata_o[B_START] && bus_wdata_o[B_STOP]));

  assert_keep_upper_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_o && bus_addr_o == RA_CTL) |-> (bus_wdata_o[7:6] == $past(bus_rdata_i[7:6])));

  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < CW'(LIMIT));

endmodule

bind i2c_regxfer_seq i2c_regxfer_seq_chk #(.LIMIT(LIMIT)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .done_o      (done_o),
  .err_o       (err_o),
  .bus_rd_o    (bus_rd_o),
  .bus_wr_o    (bus_wr_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_rdata_i (bus_rdata_i),
  .poll_cnt    (poll_cnt)
);

// File: tb/i2c_regxfer_seq_tb_top.sv
module i2c_regxfer_seq_tb_top;
  import i2c_regxfer_pkg::*;

  localparam int LIM = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, req, op_rd;
  logic [6:0] dev;
  logic [7:0] index, wbyte, rbyte, bus_wdata, bus_rdata;
  logic       done, err, bus_rd, bus_wr;
  logic [2:0] bus_addr;

  i2c_regxfer_seq #(.LIMIT(LIM)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .op_rd_i(op_rd), .dev_i(dev),
    .index_i(index), .wbyte_i(wbyte), .rbyte_o(rbyte), .done_o(done),
    .err_o(err), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  int n_tests = 0, n_fail = 0;

  // master model configuration
  int         cfg_k, cfg_fault, cfg_hang;
  logic       cfg_rd;
  logic [7:0] cfg_init, cfg_line, cfg_rx;
  logic       m_init = 1'b0;

  // master model state
  logic [7:0] m_ctl, m_stat, m_feat;
  int         m_act, m_cur, m_polls, m_spolls, m_stop_wr, m_keep_bad, log_n;
  logic       m_pend, m_spend;
  logic [7:0] log_b [8];

  function automatic logic [7:0] code_for(int a, logic rd);
    case (a)
      0: code_for = 8'h08;
      1: code_for = 8'h18;
      2: code_for = 8'h28;
      3: code_for = rd ? 8'h10 : 8'h28;
      4: code_for = 8'h40;
      default: code_for = 8'h58;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [7:0] v;
    if (m_init) begin
      m_ctl <= 8'hC0; m_stat <= cfg_init; m_feat <= 8'hFF;
      m_act <= 0; m_cur <= 0; m_polls <= 0; m_spolls <= 0;
      m_stop_wr <= 0; m_keep_bad <= 0; log_n <= 0;
      m_pend <= 1'b0; m_spend <= 1'b0; bus_rdata <= 8'h00;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          RA_DATA: begin
            if (log_n < 8) log_b[log_n] <= bus_wdata;
            log_n <= log_n + 1;
          end
          RA_FEAT: m_feat <= bus_wdata;
          RA_CTL: begin
            if (bus_wdata[7:6] != m_ctl[7:6]) m_keep_bad <= m_keep_bad + 1;
            if (bus_wdata[B_STOP]) begin
              m_ctl <= {bus_wdata[7:5], 1'b1, 1'b0, bus_wdata[2:0]};
              m_spend <= 1'b1; m_spolls <= 0; m_pend <= 1'b0;
              m_stop_wr <= m_stop_wr + 1; m_stat <= ST_IDLE;
            end else begin
              m_ctl <= {bus_wdata[7:4], 1'b0, bus_wdata[2:0]};
              m_pend <= 1'b1; m_polls <= 0; m_cur <= m_act; m_act <= m_act + 1;
            end
          end
          default: ;
        endcase
      end
      if (bus_rd) begin
        case (bus_addr)
          RA_CTL: begin
            v = m_ctl;
            if (m_pend) begin
              if (m_polls + 1 >= cfg_k && m_cur != cfg_hang) begin
                v[B_FLAG] = 1'b1; v[B_START] = 1'b0; m_pend <= 1'b0;
                m_stat <= code_for(m_cur, cfg_rd) ^ ((m_cur == cfg_fault) ? 8'h01 : 8'h00);
              end else m_polls <= m_polls + 1;
            end
            if (m_spend) begin
              if (m_spolls + 1 >= cfg_k) begin
                v[B_STOP] = 1'b0; m_spend <= 1'b0;
              end else m_spolls <= m_spolls + 1;
            end
            m_ctl <= v;
            bus_rdata <= v;
          end
          RA_STAT: bus_rdata <= m_stat;
          RA_DATA: bus_rdata <= cfg_rx;
          RA_LINE: bus_rdata <= cfg_line;
          RA_FEAT: bus_rdata <= m_feat;
          default: bus_rdata <= 8'h00;
        endcase
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int seed_n = 0;

  task automatic run_txn(input logic rd, input int k, input int fault, input int hang,
                         input logic [7:0] ist, input logic [7:0] line, input logic inject);
    logic [6:0] dv;
    logic [7:0] ix, wb, rx;
    int ndone, nact;
    logic got_err, exp_err;
    logic [7:0] got_rb;
    string tag;
    seed_n++;
    dv = 7'(7'h13 * seed_n + 5);
    ix = 8'(8'h2B * seed_n + 1);
    wb = 8'(8'h71 * seed_n + 9);
    rx = 8'(8'h3D * seed_n + 2);
    cfg_rd = rd; cfg_k = k; cfg_fault = fault; cfg_hang = hang;
    cfg_init = ist; cfg_line = line; cfg_rx = rx;
    @(negedge clk); m_init = 1'b1;
    @(negedge clk); m_init = 1'b0;
    req = 1'b1; op_rd = rd; dev = dv; index = ix; wbyte = wb;
    @(negedge clk); req = 1'b0;
    ndone = 0; got_err = 1'b0; got_rb = 8'h00;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if (inject && c == 6) begin
        req = 1'b1; op_rd = ~rd; dev = ~dv; index = ~ix; wbyte = ~wb;
      end else req = 1'b0;
      if (done) begin
        ndone++; got_err = err; got_rb = rbyte;
      end
      if (ndone > 0 && c > 40) break;
    end
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    nact = rd ? 6 : 4;
    exp_err = (ist != ST_IDLE) || (line != LINE_HIGH) || (k > LIM) ||
              (fault >= 0 && fault < nact) || (hang >= 0 && hang < nact);
    if (ist != ST_IDLE) tag = "R2";
    else if (fault >= 0) tag = "R6";
    else if (hang >= 0 || k > LIM) tag = "R5";
    else if (line != LINE_HIGH) tag = "R8";
    else tag = rd ? "R4" : "R3";
    chk(ndone == 1, inject ? "R10 single done" : "R9 single done", ndone, 1);
    chk(got_err == exp_err, {tag, " error outcome"}, got_err, exp_err);
    chk(m_stop_wr == 1, "R8 stop phase once", m_stop_wr, 1);
    chk(m_keep_bad == 0, "R7 bits 7:6 kept", m_keep_bad, 0);
    chk(m_feat == 8'h00, "R2 feature cleared", m_feat, 0);
    if (ist != ST_IDLE) chk(m_act == 0, "R2 no START when busy", m_act, 0);
    if (!exp_err) begin
      chk(m_act == nact, {tag, " action count"}, m_act, nact);
      chk(log_n == 3, {tag, " data loads"}, log_n, 3);
      chk(log_b[0] == {dv, 1'b0}, {tag, " address byte"}, log_b[0], {dv, 1'b0});
      chk(log_b[1] == ix, {tag, " index byte"}, log_b[1], ix);
      if (rd) begin
        chk(log_b[2] == {dv, 1'b1}, "R4 read address byte", log_b[2], {dv, 1'b1});
        chk(got_rb == rx, "R4 received byte", got_rb, rx);
      end else
        chk(log_b[2] == wb, "R3 write byte", log_b[2], wb);
    end
  endtask

  int cyc = 0;
  logic wd_hit = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !wd_hit) begin
      wd_hit <= 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req = 1'b0; op_rd = 1'b0; dev = '0; index = '0; wbyte = '0;
    cfg_k = 1; cfg_fault = -1; cfg_hang = -1; cfg_rd = 1'b0;
    cfg_init = ST_IDLE; cfg_line = LINE_HIGH; cfg_rx = 8'h00;
    m_init = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; m_init = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(!done && !err && !bus_rd && !bus_wr, "R1 idle after reset",
          {done, err, bus_rd, bus_wr}, 0);
    end
    for (int o = 0; o < 2; o++)
      for (int k = 1; k <= LIM + 1; k++)
        run_txn(o[0], k, -1, -1, ST_IDLE, LINE_HIGH, 1'b0);
    for (int o = 0; o < 2; o++)
      for (int f = 0; f < (o ? 6 : 4); f++)
        run_txn(o[0], 2, f, -1, ST_IDLE, LINE_HIGH, 1'b0);
    for (int o = 0; o < 2; o++)
      for (int h = 0; h < (o ? 6 : 4); h++)
        run_txn(o[0], 1, -1, h, ST_IDLE, LINE_HIGH, 1'b0);
    for (int o = 0; o < 2; o++) begin
      run_txn(o[0], 2, -1, -1, 8'h20, LINE_HIGH, 1'b0);
      run_txn(o[0], 2, -1, -1, ST_IDLE, 8'h38, 1'b0);
      run_txn(o[0], 3, -1, -1, ST_IDLE, LINE_HIGH, 1'b1);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule